// File: doc/BRIEF.md
# Ones' Complement Adder/Subtractor

A purely combinational adder/subtractor for signed words held in ones' complement form. The most significant bit is the sign. A non-negative value is its plain binary magnitude with sign 0. A negative value is the bitwise inverse of the code for the matching positive value. This gives two codes for zero: all zeros (+0) and all ones (-0).

A mode input chooses between A+B and A-B. In subtract mode the B word is inverted bit by bit, which negates it in this format. The two words are then added, with the sign bit taking part in the addition. A carry out of the sign position is added back in at the least significant bit, which is the end-around carry. The block returns the result word and an overflow flag. A -0 result is passed out unchanged and is not normalised to +0.

Top module: `oc_addsub`

## Requirements
- R1: With sub_i=0, sum_o encodes val(a_i)+val(b_i) whenever that sum lies in the range -(2^(W-1)-1) to +(2^(W-1)-1). Here val(x) is x when bit W-1 is 0, and minus the bitwise inverse of x when bit W-1 is 1.
- R2: With sub_i=1, sum_o encodes val(a_i)-val(b_i) whenever that difference is in range. It is formed as a_i plus the bitwise inverse of b_i, using the same end-around carry.
- R3: ovf_o is 1 exactly when the two words actually added (a_i and b_i, or a_i and ~b_i) share a sign bit and the sign bit of sum_o differs from it. This is the same as the true result falling outside the range.
- R4: For any a_i other than +0 (all zeros), a_i + (-0) returns the code a_i unchanged, and so does a_i - (+0).
- R5: Adding a word to its own inverse, or subtracting a word from itself, returns all ones (-0) with ovf_o=0. The -0 result is not rewritten to +0.
- R6: When the two added words have different sign bits, ovf_o is 0.
- R7: With W=5: 11100 + 01011 gives 01000, and 11100 - 01011 gives 10001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand, ones' complement |
| b_i | input | W | Second operand, ones' complement |
| sub_i | input | 1 | 0: a_i+b_i, 1: a_i-b_i |
| sum_o | output | W | Result, ones' complement |
| ovf_o | output | 1 | Signed overflow |

## Verification
The bench sweeps every operand pair in both modes at W=5 and compares the decoded result with the true signed value. Any error in the end-around carry therefore shows up as an off-by-one on every carrying sum, and any wrong inversion in subtract mode gives wrong differences. Operands equal to -0 and +0 are aimed at directly: a design that dropped the end-around carry would return A-1 for A+(-0), and one that normalised zero would break the exact all-ones code required by R5. Overflow is probed at both range ends and with mixed signs. A detector that looked at the raw B instead of the inverted B in subtract mode would flag the wrong cases.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } oc_op_e;
endpackage

// File: rtl/oc_operand_prep.sv
module oc_operand_prep #(
  parameter int W = 8
) (
  input  logic [W-1:0] b_i,
  input  oc_pkg::oc_op_e op_i,
  output logic [W-1:0] b_o
);
  logic inv;
  assign inv = (op_i == oc_pkg::OP_SUB);

  for (genvar i = 0; i < W; i++) begin : g_inv
    assign b_o[i] = b_i[i] ^ inv;
  end
endmodule

// File: rtl/oc_ripple_adder.sv
module oc_ripple_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  logic [W:0] c;
  assign c[0] = c_i;

  for (genvar i = 0; i < W; i++) begin : g_cell
    logic g, p;
    assign g        = x_i[i] & y_i[i];
    assign p        = x_i[i] ^ y_i[i];
    assign s_o[i]   = p ^ c[i];
    assign c[i+1]   = g | (p & c[i]);
  end

  assign c_o = c[W];
endmodule

// File: rtl/oc_overflow_detect.sv
module oc_overflow_detect (
  input  logic x_msb_i,
  input  logic y_msb_i,
  input  logic s_msb_i,
  output logic ovf_o
);
  assign ovf_o = (x_msb_i ~^ y_msb_i) & (s_msb_i ^ x_msb_i);

  always_comb begin
    if (!$isunknown({x_msb_i, y_msb_i, s_msb_i, ovf_o})) begin
      // mixed-sign operands can never overflow
      p_no_overflow_r6: assert (!(x_msb_i != y_msb_i) || !ovf_o)
        else $error("ovf on mixed signs");
    end
  end
endmodule

// File: rtl/oc_addsub.sv
module oc_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ALL_ZERO = {W{1'b0}};

  oc_pkg::oc_op_e op;
  logic [W-1:0]   b_eff;
  logic [W-1:0]   raw_sum;
  logic           raw_carry;
  logic           fin_carry;

  assign op = oc_pkg::oc_op_e'(sub_i);

  oc_operand_prep #(.W(W)) i_prep (
    .b_i  (b_i),
    .op_i (op),
    .b_o  (b_eff)
  );

  oc_ripple_adder #(.W(W)) i_add_main (
    .x_i (a_i),
    .y_i (b_eff),
    .c_i (1'b0),
    .s_o (raw_sum),
    .c_o (raw_carry)
  );

  // end-around carry: second pass adds the carry-out at bit 0
  oc_ripple_adder #(.W(W)) i_add_wrap (
    .x_i (raw_sum),
    .y_i (ALL_ZERO),
    .c_i (raw_carry),
    .s_o (sum_o),
    .c_o (fin_carry)
  );

  oc_overflow_detect i_ovf (
    .x_msb_i (a_i[W-1]),
    .y_msb_i (b_eff[W-1]),
    .s_msb_i (sum_o[W-1]),
    .ovf_o   (ovf_o)
  );

  always_comb begin
    if (!$isunknown({a_i, b_i, sub_i, sum_o, ovf_o, fin_carry})) begin
      p_no_final_carry_r1: assert (!fin_carry)
        else $error("end-around pass carried out");
      p_self_sub_r5: assert (!(sub_i && (a_i == b_i)) || (sum_o == ALL_ONES && !ovf_o))
        else $error("A-A not -0");
      p_add_neg_zero_r4: assert (!(!sub_i && b_i == ALL_ONES && a_i != ALL_ZERO) || (sum_o == a_i))
        else $error("A+(-0) changed A");
      p_sub_pos_zero_r2: assert (!(sub_i && b_i == ALL_ZERO && a_i != ALL_ZERO) || (sum_o == a_i))
        else $error("A-(+0) changed A");
      p_ovf_sign_r3: assert (!ovf_o || (sum_o[W-1] != a_i[W-1]))
        else $error("ovf without sign flip");
    end
  end
endmodule

// File: tb/test_oc_addsub.sv
module test_oc_addsub;
  localparam int W   = 5;
  localparam int LIM = (1 << (W - 1)) - 1;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic         sub;
  logic [W-1:0] sum;
  logic         ovf;
  int           checks = 0;
  int           errors = 0;
  bit           done   = 1'b0;

  always #10 clk = ~clk;

  oc_addsub #(.W(W)) i_oc_addsub (
    .a_i   (a),
    .b_i   (b),
    .sub_i (sub),
    .sum_o (sum),
    .ovf_o (ovf)
  );

  function automatic int val(logic [W-1:0] x);
    logic [W-1:0] inv;
    inv = ~x;
    return x[W-1] ? -int'(inv) : int'(x);
  endfunction

  task automatic apply(logic [W-1:0] ta, logic [W-1:0] tb, logic ts);
    @(posedge clk);
    a = ta; b = tb; sub = ts;
    @(negedge clk);
  endtask

  task automatic chk_int(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s a=%b b=%b sub=%0d got=%0d exp=%0d", req, a, b, sub, got, exp);
    end
  endtask

  task automatic chk_code(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s a=%b b=%b sub=%0d got=%b exp=%b", req, a, b, sub, got, exp);
    end
  endtask

  task automatic t_worked; // R7
    apply(5'b11100, 5'b01011, 1'b0);
    chk_code("R7 add", sum, 5'b01000);
    chk_int("R7 add ovf", int'(ovf), 0);
    apply(5'b11100, 5'b01011, 1'b1);
    chk_code("R7 sub", sum, 5'b10001);
    chk_int("R7 sub ovf", int'(ovf), 0);
  endtask

  task automatic t_neg_zero; // R4, R5
    for (int i = 1; i < (1 << W); i++) begin
      apply(W'(i), '1, 1'b0);
      chk_code("R4 A+(-0)", sum, W'(i));
      apply(W'(i), '0, 1'b1);
      chk_code("R4 A-(+0)", sum, W'(i));
    end
    apply(5'b00101, 5'b11010, 1'b0);
    chk_code("R5 x+(-x)", sum, 5'b11111);
    chk_int("R5 ovf", int'(ovf), 0);
    apply(5'b01001, 5'b01001, 1'b1);
    chk_code("R5 A-A", sum, 5'b11111);
    chk_int("R5 ovf", int'(ovf), 0);
    apply(5'b11111, 5'b11111, 1'b0);
    chk_code("R5 -0+-0", sum, 5'b11111);
  endtask

  task automatic t_range_edges; // R3, R6
    apply(5'b01111, 5'b00001, 1'b0);
    chk_int("R3 +15+1", int'(ovf), 1);
    apply(5'b10000, 5'b00001, 1'b1);
    chk_int("R3 -15-1", int'(ovf), 1);
    apply(5'b01110, 5'b00001, 1'b0);
    chk_int("R3 +14+1", int'(ovf), 0);
    chk_code("R3 +14+1 code", sum, 5'b01111);
    apply(5'b01111, 5'b10000, 1'b0);
    chk_int("R6 +15+-15", int'(ovf), 0);
    apply(5'b10000, 5'b10000, 1'b1);
    chk_int("R6 -15-(-15)", int'(ovf), 0);
  endtask

  task automatic t_sweep; // R1, R2, R3
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < (1 << W); i++) begin
        for (int j = 0; j < (1 << W); j++) begin
          int s;
          apply(W'(i), W'(j), m[0]);
          s = val(W'(i)) + (m[0] ? -val(W'(j)) : val(W'(j)));
          if (s > LIM || s < -LIM) begin
            chk_int("R3 sweep ovf", int'(ovf), 1);
          end else if (ovf) begin
            chk_int(m[0] ? "R2 R3 sweep ovf" : "R1 R3 sweep ovf", int'(ovf), 0);
          end else begin
            chk_int(m[0] ? "R2 sweep" : "R1 sweep", val(sum), s);
          end
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; sub = 1'b0;
    @(negedge clk);
    chk_code("R1 idle", sum, '0);
    t_worked();
    t_neg_zero();
    t_range_edges();
    t_sweep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule